// File: doc/BRIEF.md
# DMA Source-Chain Tag Sequencer

This block is the sequencing core of one DMA channel that walks a linked list of tags in memory. Each tag is a pair of 32-bit words. The first word carries the tag kind, a quadword count, an interrupt request bit and a set of attribute bits. The second word carries an address. The block takes one tag at a time, updates its channel registers and issues a packet descriptor that gives the byte address and quadword count of the data to move. It also reports whether the chain goes on, and whether it stopped because of a fault.

Some tag kinds branch to a subroutine list and return from it later. For these the block keeps a two-entry return-address stack in two dedicated registers. The stack fill level is kept in two bits of the control register. Software can read and write every channel register through a simple register port, and that port is also how the chain is set up before the first tag arrives. The block does not fetch tags and does not move any payload. Whatever drives it presents each tag with a one-cycle valid strobe.

Top module: `dma_tag_seq`

## Requirements
- R1: The tag kind is taken from tag bits 30:28, the quadword count from bits 15:0, and the address from bits 63:32. The kind codes are 0 REFE, 1 CNT, 2 NEXT, 3 REF, 4 REFS, 5 CALL, 6 RET, 7 END. The packet count always equals the tag count.
- R2: Every accepted tag copies tag bits 31:16 into control bits 31:16. Control bits 15:6 and 3:0 are kept, and only stack operations change the depth field (bits 5:4: 0 empty, 1 one entry, 2 two entries).
- R3: For CNT, with tag address T and count Q, the packet starts at T+16. The next tag address becomes T+16+16·Q, and the chain continues.
- R4: For NEXT, the packet starts at T+16, the next tag address becomes the tag's address field, and the chain continues.
- R5: For REF and REFS, the packet starts at the address field, the next tag address becomes T+16, and the chain continues.
- R6: For REFE, the packet starts at the address field, the tag address is unchanged, and the chain ends.
- R7: For END, the data address becomes T+16, the tag address is unchanged, and the chain ends.
- R8: For CALL, the packet starts at T+16 and the next tag address becomes the address field. The return address T+16+16·Q goes to return slot 0 when the depth is 0 (the depth becomes 1), or to return slot 1 when the depth is 1 (the depth becomes 2).
- R9: For RET at depth 2, the next tag address is taken from slot 1, slot 1 is cleared and the depth becomes 1. At depth 1 it is taken from slot 0, slot 0 is cleared and the depth becomes 0. The packet starts at T+16.
- R10: A CALL at depth 2 or a RET at depth 0 issues no packet and raises both the done and error pulses. It changes only control bits 31:16.
- R11: When control bit 7 and tag bit 31 are both set, the packet is still issued, the chain ends and the count register is cleared.
- R12: Outputs and registers change one cycle after the accepting edge. Packet, done and error are single-cycle pulses. A tag wins over a register write in the same cycle. The register map is 0 control, 1 data address, 2 count, 3 tag address, 4 slot 0, 5 slot 1, and any other index reads 0.
- R13: After reset every register and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_valid | input | 1 | Tag strobe, one cycle per tag |
| tag_data | input | 64 | Lower two words of the tag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| pkt_valid | output | 1 | Packet descriptor pulse |
| pkt_addr | output | 32 | Packet start byte address |
| pkt_qwc | output | 16 | Packet quadword count |
| chain_done | output | 1 | Chain-end pulse |
| chain_err | output | 1 | Stack-fault pulse |

## Verification
Every result of a tag appears exactly one edge after the edge that accepts it. This covers the packet pulse, the done and error pulses and all the register updates. The bench drives each tag for one cycle starting at a falling edge, then samples the pulses at the next falling edge. Still inside that same low phase, it reads every register through the combinational read port, so the single-cycle pulses are caught before they drop. A register write becomes visible on the read port after one edge, and the bench checks the case where a write and a tag collide in the same cycle.

// File: rtl/dma_tag_seq.sv
module dma_tag_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_valid,
  input  logic [63:0]       tag_data,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              pkt_valid,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [CNT_W-1:0]  pkt_qwc,
  output logic              chain_done,
  output logic              chain_err
);
  localparam logic [ADDR_W-1:0] QW_BYTES = ADDR_W'(16);
  localparam logic [2:0] K_REFE = 3'd0, K_CNT = 3'd1, K_NEXT = 3'd2, K_REF = 3'd3,
                         K_REFS = 3'd4, K_CALL = 3'd5, K_RET = 3'd6, K_END = 3'd7;

  logic [31:0]       ctl;
  logic [ADDR_W-1:0] madr, tadr, slot0, slot1;
  logic [CNT_W-1:0]  qwc;

  wire [2:0]        kind   = tag_data[30:28];
  wire [CNT_W-1:0]  tcnt   = tag_data[CNT_W-1:0];
  wire [ADDR_W-1:0] taddr  = tag_data[32 +: ADDR_W];
  wire [1:0]        depth  = ctl[5:4];
  wire [ADDR_W-1:0] follow = tadr + QW_BYTES;
  wire [ADDR_W-1:0] after  = follow + (ADDR_W'(tcnt) << 4);
  wire              irq    = ctl[7] & tag_data[31];
  wire              fault  = (kind == K_CALL && depth[1]) || (kind == K_RET && depth == 2'd0);

  logic [ADDR_W-1:0] n_madr, n_tadr, n_slot0, n_slot1;
  logic [1:0]        n_depth;
  logic              last;

  always_comb begin
    n_madr  = follow;
    n_tadr  = tadr;
    n_slot0 = slot0;
    n_slot1 = slot1;
    n_depth = depth;
    last    = 1'b0;
    case (kind)
      K_REFE: begin n_madr = taddr; last = 1'b1; end
      K_CNT:  n_tadr = after;
      K_NEXT: n_tadr = taddr;
      K_REF, K_REFS: begin n_madr = taddr; n_tadr = follow; end
      K_CALL: begin
        n_tadr = taddr;
        if (depth == 2'd0) begin n_slot0 = after; n_depth = 2'd1; end
        else if (depth == 2'd1) begin n_slot1 = after; n_depth = 2'd2; end
      end
      K_RET: begin
        if (depth[1]) begin n_tadr = slot1; n_slot1 = '0; n_depth = 2'd1; end
        else if (depth == 2'd1) begin n_tadr = slot0; n_slot0 = '0; n_depth = 2'd0; end
      end
      default: last = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0; madr <= '0; tadr <= '0; slot0 <= '0; slot1 <= '0; qwc <= '0;
      pkt_valid <= 1'b0; pkt_addr <= '0; pkt_qwc <= '0;
      chain_done <= 1'b0; chain_err <= 1'b0;
    end else begin
      pkt_valid  <= 1'b0;
      chain_done <= 1'b0;
      chain_err  <= 1'b0;
      if (tag_valid) begin
        if (fault) begin
          ctl        <= {tag_data[31:16], ctl[15:0]};
          chain_done <= 1'b1;
          chain_err  <= 1'b1;
        end else begin
          ctl        <= {tag_data[31:16], ctl[15:6], n_depth, ctl[3:0]};
          madr       <= n_madr;
          tadr       <= n_tadr;
          slot0      <= n_slot0;
          slot1      <= n_slot1;
          qwc        <= irq ? '0 : tcnt;
          pkt_valid  <= 1'b1;
          pkt_addr   <= n_madr;
          pkt_qwc    <= tcnt;
          chain_done <= last | irq;
        end
      end else if (reg_we) begin
        case (reg_addr)
          3'd0: ctl   <= reg_wdata;
          3'd1: madr  <= reg_wdata[ADDR_W-1:0];
          3'd2: qwc   <= reg_wdata[CNT_W-1:0];
          3'd3: tadr  <= reg_wdata[ADDR_W-1:0];
          3'd4: slot0 <= reg_wdata[ADDR_W-1:0];
          3'd5: slot1 <= reg_wdata[ADDR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = ctl;
      3'd1:    reg_rdata = 32'(madr);
      3'd2:    reg_rdata = 32'(qwc);
      3'd3:    reg_rdata = 32'(tadr);
      3'd4:    reg_rdata = 32'(slot0);
      3'd5:    reg_rdata = 32'(slot1);
      default: reg_rdata = '0;
    endcase
  end

  AST_ERR_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    chain_err |-> chain_done && !pkt_valid); // R10
  AST_CTL_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |=> ctl[15:6] == $past(ctl[15:6]) && ctl[3:0] == $past(ctl[3:0])); // R2
  AST_END_TADR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid && (kind == K_END || kind == K_REFE) |=> tadr == $past(tadr)); // R7
  AST_IRQ_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid && irq && !fault |=> chain_done && qwc == '0); // R11
  AST_PKT_MATCHES_MADR: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> pkt_addr == madr); // R12
  AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid && kind == K_CALL && depth == 2'd0 |=> ctl[5:4] == 2'd1 && slot0 == $past(after)); // R8
endmodule

// File: tb/dma_tag_seq_tb.sv
`timescale 1ns/1ps
module dma_tag_seq_tb;
  logic clk = 0, rst_n = 0, tag_valid = 0, reg_we = 0;
  logic [63:0] tag_data = '0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic pkt_valid, chain_done, chain_err;
  logic [31:0] pkt_addr;
  logic [15:0] pkt_qwc;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dma_tag_seq u_dut (.clk, .rst_n, .tag_valid, .tag_data, .reg_we, .reg_addr, .reg_wdata,
                     .reg_rdata, .pkt_valid, .pkt_addr, .pkt_qwc, .chain_done, .chain_err);

  logic [31:0] m_ctl, m_madr, m_tadr, m_s0, m_s1, m_qwc;
  logic e_pv, e_done, e_err; logic [31:0] e_pa; logic [15:0] e_pq;
  string lbl;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic check_regs(string r);
    logic [31:0] v;
    rd(0, v); chk("R2 control", v, m_ctl);
    rd(1, v); chk({r, " madr"}, v, m_madr);
    rd(2, v); chk({r, " qwc"}, v, m_qwc);
    rd(3, v); chk({r, " tadr"}, v, m_tadr);
    rd(4, v); chk({r, " slot0"}, v, m_s0);
    rd(5, v); chk({r, " slot1"}, v, m_s1);
  endtask

  function automatic string req_of(logic [2:0] k);
    case (k)
      3'd0: return "R6"; 3'd1: return "R3"; 3'd2: return "R4";
      3'd3, 3'd4: return "R5"; 3'd5: return "R8"; 3'd6: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic model(logic [31:0] w0, logic [31:0] w1);
    logic [2:0] k = w0[30:28]; logic [15:0] q = w0[15:0];
    logic [1:0] d = m_ctl[5:4];
    logic [31:0] fol = m_tadr + 32'd16, aft = m_tadr + 32'd16 + {12'd0, q, 4'd0};
    logic irq = m_ctl[7] & w0[31], last = 0;
    e_pv = 0; e_done = 0; e_err = 0; e_pa = 0; e_pq = 0;
    lbl = req_of(k);
    m_ctl[31:16] = w0[31:16];
    if ((k == 5 && d >= 2) || (k == 6 && d == 0)) begin
      e_done = 1; e_err = 1; lbl = "R10";
      return;
    end
    case (k)
      0: begin m_madr = w1; last = 1; end
      1: begin m_madr = fol; m_tadr = aft; end
      2: begin m_madr = fol; m_tadr = w1; end
      3, 4: begin m_madr = w1; m_tadr = fol; end
      5: begin m_madr = fol; m_tadr = w1;
           if (d == 0) begin m_s0 = aft; m_ctl[5:4] = 1; end
           else begin m_s1 = aft; m_ctl[5:4] = 2; end end
      6: begin m_madr = fol;
           if (d >= 2) begin m_tadr = m_s1; m_s1 = 0; m_ctl[5:4] = 1; end
           else begin m_tadr = m_s0; m_s0 = 0; m_ctl[5:4] = 0; end end
      default: begin m_madr = fol; last = 1; end
    endcase
    if (irq) lbl = "R11";
    m_qwc = irq ? 0 : {16'd0, q};
    e_pv = 1; e_pa = m_madr; e_pq = q; e_done = last | irq;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] v);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 0;
    case (a)
      0: m_ctl = v; 1: m_madr = v; 2: m_qwc = {16'd0, v[15:0]};
      3: m_tadr = v; 4: m_s0 = v; 5: m_s1 = v; default: ;
    endcase
  endtask

  task automatic send(logic [31:0] w0, logic [31:0] w1, logic with_wr = 0);
    model(w0, w1);
    @(negedge clk); tag_valid = 1; tag_data = {w1, w0};
    if (with_wr) begin reg_we = 1; reg_addr = 1; reg_wdata = 32'hDEAD0000; end
    @(negedge clk); tag_valid = 0; reg_we = 0;
    chk({lbl, " pkt_valid"}, 32'(pkt_valid), 32'(e_pv));
    if (e_pv) begin
      chk({lbl, " pkt_addr"}, pkt_addr, e_pa);
      chk("R1 pkt_qwc", 32'(pkt_qwc), 32'(e_pq));
    end
    chk({lbl, " done"}, 32'(chain_done), 32'(e_done));
    chk({lbl, " err"}, 32'(chain_err), 32'(e_err));
    check_regs(lbl);
    @(negedge clk);
    chk("R12 pulse width", 32'({pkt_valid, chain_done, chain_err}), 0);
  endtask

  function automatic logic [31:0] mk(logic irqb, logic [2:0] k, logic [11:0] attr, logic [15:0] q);
    return {irqb, k, attr, q};
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED));
    m_ctl = 0; m_madr = 0; m_tadr = 0; m_s0 = 0; m_s1 = 0; m_qwc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R13 reset outputs", 32'({pkt_valid, chain_done, chain_err}), 0);
    chk("R13 reset pkt_addr", pkt_addr, 0);
    check_regs("R13");

    wr(3, 32'h0000_1000);
    check_regs("R12 write");
    send(mk(0, 1, 12'hABC, 3), 32'h0);
    send(mk(0, 5, 12'h000, 2), 32'h0000_4000);
    send(mk(0, 5, 12'h001, 1), 32'h0000_8000);
    send(mk(0, 5, 12'h002, 4), 32'h0000_C000);
    send(mk(0, 6, 12'h003, 2), 32'h0);
    send(mk(0, 6, 12'h004, 0), 32'h0);
    send(mk(0, 6, 12'h005, 1), 32'h0);
    send(mk(0, 2, 12'h006, 5), 32'h0002_0000);
    send(mk(0, 3, 12'h007, 7), 32'h0003_0000);
    send(mk(0, 4, 12'h008, 9), 32'h0003_1000);
    send(mk(0, 0, 12'h009, 6), 32'h0005_0000);
    send(mk(0, 7, 12'h00A, 8), 32'h0);
    send(mk(1, 1, 12'h00B, 4), 32'h0);
    wr(0, 32'h0000_0F80);
    send(mk(1, 1, 12'h00C, 4), 32'h0);
    send(mk(0, 1, 12'h00D, 2), 32'h0, 1);
    rd(7, v); chk("R12 unmapped index", v, 0);
    rd(6, v); chk("R12 unmapped index", v, 0);

    for (int i = 0; i < 300; i++) begin
      if ($urandom % 10 == 0)
        wr(0, {16'd0, 8'd0, ($urandom % 2 == 0), 1'b0, m_ctl[5:4], 4'd0});
      if ($urandom % 15 == 0) wr(3, $urandom & 32'hFFFF_FFF0);
      send(mk($urandom % 2 == 0, 3'($urandom % 8), 12'($urandom), 16'($urandom % 64)),
           $urandom & 32'hFFFF_FFF0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule